// File: doc/BRIEF.md
# Multi-Channel Successive-Approximation Converter Sequencer

This block is the digital half of an eight-input, 10-bit successive-approximation converter. It picks an analog input through a channel-select output and opens a one-period sample window. It then presents a trial code to the resistor DAC on each conversion-clock period and reads the comparator's decision back, one bit at a time from the most significant bit down. A programmable divider derives the conversion clock from the system clock.

A conversion can be started by a software pulse, by a chosen edge on an external pin or on a timer-match pulse, or by a burst scan. A burst scan keeps converting the enabled channels of an 8-bit mask in ascending order. Every channel owns a result register with a fresh-result flag and an overwrite flag, and these can be read independently of the other channels. An interrupt line reports fresh results on the channels that have their interrupt enabled. A power-down input halts all activity and parks the analog interface.

Top module: `sar_adc_seq`

## Requirements
- R1: The comparator input `cmp_in` reads 1 when the analog input is at or above `dac_code`. The block decides bit 9 first and bit 0 last, so an input value V in 0..1023 yields a result equal to V.
- R2: One conversion lasts 11 conversion-clock periods: one sample period with `sample` high and `dac_code` zero, then ten decision periods. A conversion-clock period is `clk_div`+1 system cycles, so `busy` stays high for exactly 11×(`clk_div`+1) cycles in a single conversion.
- R3: A `start_sw` pulse converts the lowest-numbered channel whose `ch_mask` bit is set, once, and the block then returns to idle. A pulse that arrives while `busy` is high is ignored.
- R4: While `burst_en` is high, the block converts the channels whose mask bits are set back to back. It steps to the next higher enabled channel and wraps from the highest enabled channel to the lowest. Channels whose mask bit is clear are skipped.
- R5: `trig_sel` picks the start source: 1 = `trig_pin`, 2 = `tmr_match`, 0 or 3 = no edge start. `trig_fall` picks the edge: 0 = rising, 1 = falling. The source passes through a two-stage synchroniser. An edge seen while a conversion runs starts nothing.
- R6: Each channel stores its result in its own register. Reading one channel leaves the data and flags of every other channel unchanged.
- R7: Writing a result sets that channel's done flag. A read, which is `rd_en` high with `rd_ch` selecting the channel on a clock edge, clears it. `rd_data`, `rd_done` and `rd_ovr` show the selected channel's register before the clear.
- R8: The overrun flag of a channel is set when a result is written while its done flag is still set. A read clears it.
- R9: While `pwr_dn` is high, from the next cycle `busy` and `sample` are low, `dac_code` and `ana_ch` are zero, and starts of every kind are ignored. Stored results are kept.
- R10: `irq` is high exactly while some channel has both its `int_en` bit and its done flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_dn | input | 1 | Power-down: halts conversions and parks the analog side |
| clk_div | input | 8 | Conversion-clock divider; period is clk_div+1 cycles |
| start_sw | input | 1 | Software start pulse |
| burst_en | input | 1 | Continuous scan of the enabled channels |
| ch_mask | input | 8 | Channel enable mask |
| trig_sel | input | 2 | Edge-start source: 1 pin, 2 timer match, else none |
| trig_fall | input | 1 | Edge-start polarity: 0 rising, 1 falling |
| trig_pin | input | 1 | Asynchronous external start pin |
| tmr_match | input | 1 | Timer match pulse |
| int_en | input | 8 | Per-channel interrupt enable |
| rd_en | input | 1 | Read strobe; clears the selected channel's flags |
| rd_ch | input | 3 | Channel selected for reading |
| rd_data | output | 10 | Result of the selected channel |
| rd_done | output | 1 | Done flag of the selected channel |
| rd_ovr | output | 1 | Overrun flag of the selected channel |
| irq | output | 1 | Interrupt: enabled channel has a fresh result |
| busy | output | 1 | A conversion is in progress |
| ana_ch | output | 3 | Analog multiplexer channel select |
| dac_code | output | 10 | Trial code to the resistor DAC |
| sample | output | 1 | Sample-and-hold strobe |
| cmp_in | input | 1 | Comparator decision |

## Verification
A wrong decision register or bit pointer shows up as a wrong `rd_data` value as soon as the conversion ends, at most 11 conversion-clock periods later. A full sweep of all 1024 input values catches any single stuck or misrouted bit. A fault in the scan order or the channel pointer shows on `ana_ch` at the very next rising edge of `sample`. A fault in the flag logic shows on `rd_done`, `rd_ovr` or `irq` in the cycle after the read or write that should have changed it. The power-down and trigger-gating paths are judged by whether `busy` rises at all within a fixed window after the stimulus.

// File: rtl/sar_pkg.sv
// Package: shared encodings for the converter sequencer.
// Assumes: users import it before any sequencer module is compiled.
package sar_pkg;

    // Conversion state of the successive-approximation engine
    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_SAMP = 2'd1,
        S_BITS = 2'd2
    } conv_state_t;

    // Edge-start source select encoding
    typedef enum logic [1:0] {
        TRG_NONE = 2'd0,
        TRG_PIN  = 2'd1,
        TRG_TMR  = 2'd2,
        TRG_RSVD = 2'd3
    } trig_src_t;

endpackage

// File: rtl/sar_clk_div.sv
// Module: conversion-clock enable generator.
// Produces a one-cycle tick every DIV+1 system cycles; held off in power-down.
// Assumes: the divider value is static during a conversion.
module sar_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_dn,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    // Free-running period counter, restarted on terminal count or power-down
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (pwr_dn || cnt_q >= div) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Tick marks the last system cycle of each conversion-clock period
    always_comb begin
        tick = !pwr_dn && (cnt_q >= div);
    end

endmodule

// File: rtl/sar_trig_sync.sv
// Module: edge-start detector.
// Synchronises the pin and the timer-match source through two flops each,
// keeps one more stage for history and flags the selected edge of the
// selected source. Assumes the inputs may be asynchronous to clk.
module sar_trig_sync
    import sar_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  logic       tmr,
    input  logic [1:0] sel,
    input  logic       fall,
    output logic       evt
);

    localparam int NSRC = 2;

    logic [NSRC-1:0] raw;
    logic [NSRC-1:0] s1_q, s2_q, s3_q;
    logic            cur, prev;

    assign raw = {tmr, pin};

    // Two-stage synchroniser plus one history stage per source
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
            s3_q <= '0;
        end else begin
            s1_q <= raw;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    // Current and previous level of the chosen source, then edge match
    always_comb begin
        cur  = 1'b0;
        prev = 1'b0;
        case (trig_src_t'(sel))
            TRG_PIN: begin cur = s2_q[0]; prev = s3_q[0]; end
            TRG_TMR: begin cur = s2_q[1]; prev = s3_q[1]; end
            default: begin cur = 1'b0;    prev = 1'b0;    end
        endcase
        evt = fall ? (prev && !cur) : (cur && !prev);
    end

endmodule

// File: rtl/sar_engine.sv
// Module: successive-approximation control engine.
// Chooses the channel, runs one sample period and RES bit-decision periods
// per conversion, MSB first, and emits a write strobe with the final code.
// Assumes: tick is a one-cycle enable; cmp_in is valid for the whole period
// in which dac_code is presented.
module sar_engine
    import sar_pkg::*;
#(
    parameter int NCH = 8,
    parameter int RES = 10,
    parameter int CW  = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pwr_dn,
    input  logic           tick,
    input  logic           start_req,
    input  logic           burst_en,
    input  logic [NCH-1:0] ch_mask,
    input  logic           cmp_in,
    output logic           busy,
    output logic           sample,
    output logic [CW-1:0]  ana_ch,
    output logic [RES-1:0] dac_code,
    output logic           wr_en,
    output logic [CW-1:0]  wr_ch,
    output logic [RES-1:0] wr_data
);

    localparam int BW = $clog2(RES);

    conv_state_t    state_q;
    logic [CW-1:0]  ch_q;
    logic [RES-1:0] code_q;
    logic [BW-1:0]  bit_q;
    logic           pend_q;
    logic [RES-1:0] trial_bit;
    logic [RES-1:0] decided;

    // Lowest enabled channel in the mask (0 when the mask is empty)
    function automatic logic [CW-1:0] first_ch(input logic [NCH-1:0] m);
        logic [CW-1:0] r;
        r = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (m[i]) r = CW'(i);
        end
        return r;
    endfunction

    // Next enabled channel above cur, wrapping to the lowest enabled one
    function automatic logic [CW-1:0] next_ch(input logic [NCH-1:0] m,
                                              input logic [CW-1:0]  cur);
        logic [CW-1:0] r;
        r = first_ch(m);
        for (int i = NCH - 1; i >= 0; i--) begin
            if (m[i] && (i > int'(cur))) r = CW'(i);
        end
        return r;
    endfunction

    // Apply the comparator decision to the bit under trial
    always_comb begin
        trial_bit = RES'(1) << bit_q;
        decided   = cmp_in ? code_q : (code_q & ~trial_bit);
    end

    // Conversion sequencing: idle -> sample -> RES decisions -> idle/next
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            ch_q    <= '0;
            code_q  <= '0;
            bit_q   <= '0;
            pend_q  <= 1'b0;
        end else if (pwr_dn) begin
            state_q <= S_IDLE;
            ch_q    <= '0;
            code_q  <= '0;
            bit_q   <= '0;
            pend_q  <= 1'b0;
        end else begin
            if (start_req && state_q == S_IDLE) pend_q <= 1'b1;
            case (state_q)
                S_IDLE: begin
                    if (tick && (pend_q || burst_en)) begin
                        pend_q <= 1'b0;
                        if (|ch_mask) begin
                            state_q <= S_SAMP;
                            ch_q    <= first_ch(ch_mask);
                            code_q  <= '0;
                        end
                    end
                end
                S_SAMP: begin
                    if (tick) begin
                        state_q <= S_BITS;
                        bit_q   <= BW'(RES - 1);
                        code_q  <= RES'(1) << (RES - 1);
                    end
                end
                S_BITS: begin
                    if (tick) begin
                        if (bit_q == '0) begin
                            code_q <= '0;
                            if (burst_en && |ch_mask) begin
                                state_q <= S_SAMP;
                                ch_q    <= next_ch(ch_mask, ch_q);
                            end else begin
                                state_q <= S_IDLE;
                            end
                        end else begin
                            code_q <= decided | (RES'(1) << (bit_q - 1'b1));
                            bit_q  <= bit_q - 1'b1;
                        end
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Analog-side outputs and the result write strobe
    always_comb begin
        busy     = (state_q != S_IDLE);
        sample   = (state_q == S_SAMP);
        ana_ch   = ch_q;
        dac_code = (state_q == S_BITS) ? code_q : '0;
        wr_en    = !pwr_dn && tick && (state_q == S_BITS) && (bit_q == '0);
        wr_ch    = ch_q;
        wr_data  = decided;
    end

endmodule

// File: rtl/sar_result_bank.sv
// Module: per-channel result registers with done and overrun flags.
// A write sets done and raises overrun if done was still set; a read clears
// both. A read in the same cycle as a write to that channel counts as first.
// Assumes: at most one write and one read per cycle.
module sar_result_bank #(
    parameter int NCH = 8,
    parameter int RES = 10,
    parameter int CW  = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [CW-1:0]  wr_ch,
    input  logic [RES-1:0] wr_data,
    input  logic           rd_en,
    input  logic [CW-1:0]  rd_ch,
    output logic [RES-1:0] rd_data,
    output logic           rd_done,
    output logic           rd_ovr,
    output logic [NCH-1:0] done_vec
);

    logic [NCH*RES-1:0] data_flat;
    logic [NCH-1:0]     ovr_vec;

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic [RES-1:0] data_q;
        logic           done_q;
        logic           ovr_q;
        logic           hit_w;
        logic           hit_r;

        assign hit_w = wr_en && (wr_ch == CW'(g));
        assign hit_r = rd_en && (rd_ch == CW'(g));

        // Channel register update: write wins over read-clear
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q <= '0;
                done_q <= 1'b0;
                ovr_q  <= 1'b0;
            end else if (hit_w) begin
                data_q <= wr_data;
                done_q <= 1'b1;
                ovr_q  <= (done_q || ovr_q) && !hit_r;
            end else if (hit_r) begin
                done_q <= 1'b0;
                ovr_q  <= 1'b0;
            end
        end

        assign data_flat[g*RES +: RES] = data_q;
        assign done_vec[g]             = done_q;
        assign ovr_vec[g]              = ovr_q;
    end

    // Read-side multiplexer
    always_comb begin
        rd_data = data_flat[rd_ch*RES +: RES];
        rd_done = done_vec[rd_ch];
        rd_ovr  = ovr_vec[rd_ch];
    end

endmodule

// File: rtl/sar_adc_seq.sv
// Module: multi-channel successive-approximation converter sequencer (top).
// Joins the conversion-clock divider, edge-start detector, conversion engine
// and result bank, and forms the interrupt line.
// Assumes: analog comparator, sample-and-hold and DAC are external.
module sar_adc_seq #(
    parameter  int NCH   = 8,
    parameter  int RES   = 10,
    parameter  int DIV_W = 8,
    localparam int CW    = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_dn,
    input  logic [DIV_W-1:0] clk_div,
    input  logic             start_sw,
    input  logic             burst_en,
    input  logic [NCH-1:0]   ch_mask,
    input  logic [1:0]       trig_sel,
    input  logic             trig_fall,
    input  logic             trig_pin,
    input  logic             tmr_match,
    input  logic [NCH-1:0]   int_en,
    input  logic             rd_en,
    input  logic [CW-1:0]    rd_ch,
    output logic [RES-1:0]   rd_data,
    output logic             rd_done,
    output logic             rd_ovr,
    output logic             irq,
    output logic             busy,
    output logic [CW-1:0]    ana_ch,
    output logic [RES-1:0]   dac_code,
    output logic             sample,
    input  logic             cmp_in
);

    logic           tick;
    logic           trig_evt;
    logic           start_req;
    logic           wr_en;
    logic [CW-1:0]  wr_ch;
    logic [RES-1:0] wr_data;
    logic [NCH-1:0] done_vec;

    assign start_req = start_sw || trig_evt;

    sar_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .pwr_dn (pwr_dn),
        .div    (clk_div),
        .tick   (tick)
    );

    sar_trig_sync u_trig (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (trig_pin),
        .tmr   (tmr_match),
        .sel   (trig_sel),
        .fall  (trig_fall),
        .evt   (trig_evt)
    );

    sar_engine #(.NCH(NCH), .RES(RES), .CW(CW)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_dn    (pwr_dn),
        .tick      (tick),
        .start_req (start_req),
        .burst_en  (burst_en),
        .ch_mask   (ch_mask),
        .cmp_in    (cmp_in),
        .busy      (busy),
        .sample    (sample),
        .ana_ch    (ana_ch),
        .dac_code  (dac_code),
        .wr_en     (wr_en),
        .wr_ch     (wr_ch),
        .wr_data   (wr_data)
    );

    sar_result_bank #(.NCH(NCH), .RES(RES), .CW(CW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_ch    (wr_ch),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_ch    (rd_ch),
        .rd_data  (rd_data),
        .rd_done  (rd_done),
        .rd_ovr   (rd_ovr),
        .done_vec (done_vec)
    );

    // Interrupt: any enabled channel holding an unread result
    always_comb begin
        irq = |(done_vec & int_en);
    end

endmodule

// File: rtl/sar_adc_seq_chk.sv
// Module: temporal checks on the sequencer ports, attached by bind.
// Assumes: synchronous active-low reset on rst_n.
module sar_adc_seq_chk #(
    parameter int NCH = 8,
    parameter int RES = 10,
    parameter int CW  = $clog2(NCH)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           pwr_dn,
    input logic           busy,
    input logic           sample,
    input logic [CW-1:0]  ana_ch,
    input logic [RES-1:0] dac_code,
    input logic           irq,
    input logic [NCH-1:0] int_en
);

    // R9
    pd_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> (!busy && !sample && dac_code == '0 && ana_ch == '0));

    // R2
    conv_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> sample);

    // R4
    ch_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_dn && !$past(pwr_dn) && ana_ch != $past(ana_ch)) |-> sample);

    // R1
    trial_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !sample) |-> (dac_code != '0));

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_en == '0) |-> !irq);

endmodule

bind sar_adc_seq sar_adc_seq_chk #(.NCH(NCH), .RES(RES), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_dn   (pwr_dn),
    .busy     (busy),
    .sample   (sample),
    .ana_ch   (ana_ch),
    .dac_code (dac_code),
    .irq      (irq),
    .int_en   (int_en)
);

// File: tb/sar_adc_seq_tb.sv
// Bench: sweeps input codes, dividers, channels, scan masks and start
// sources; expected values are computed from the requirements.
module sar_adc_seq_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_dn = 1'b0;
    logic [7:0] clk_div = 8'd0;
    logic       start_sw = 1'b0;
    logic       burst_en = 1'b0;
    logic [7:0] ch_mask = 8'd0;
    logic [1:0] trig_sel = 2'd0;
    logic       trig_fall = 1'b0;
    logic       trig_pin = 1'b0;
    logic       tmr_match = 1'b0;
    logic [7:0] int_en = 8'd0;
    logic       rd_en = 1'b0;
    logic [2:0] rd_ch = 3'd0;
    logic [9:0] rd_data;
    logic       rd_done;
    logic       rd_ovr;
    logic       irq;
    logic       busy;
    logic [2:0] ana_ch;
    logic [9:0] dac_code;
    logic       sample;
    logic       cmp_in;

    logic [9:0] vin [8];
    int n_cmp = 0;
    int n_bad = 0;
    int n_rise = 0;
    int nlog = 0;
    int log_ch [64];
    logic prev_samp = 1'b0;

    always #4 clk = ~clk;

    // Behavioural comparator: analog input at or above the trial code
    assign cmp_in = (vin[ana_ch] >= dac_code);

    sar_adc_seq u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .clk_div(clk_div),
        .start_sw(start_sw), .burst_en(burst_en), .ch_mask(ch_mask),
        .trig_sel(trig_sel), .trig_fall(trig_fall), .trig_pin(trig_pin),
        .tmr_match(tmr_match), .int_en(int_en), .rd_en(rd_en), .rd_ch(rd_ch),
        .rd_data(rd_data), .rd_done(rd_done), .rd_ovr(rd_ovr), .irq(irq),
        .busy(busy), .ana_ch(ana_ch), .dac_code(dac_code), .sample(sample),
        .cmp_in(cmp_in)
    );

    // Log the channel at every start of a sample window
    always @(posedge clk) begin
        prev_samp <= sample;
        if (sample && !prev_samp) begin
            n_rise <= n_rise + 1;
            if (nlog < 64) log_ch[nlog] <= int'(ana_ch);
            nlog <= nlog + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_conv(output int blen);
        int t = 0;
        blen = 0;
        while (!busy && t < 5000) begin @(negedge clk); t++; end
        while (busy && t < 5000) begin @(negedge clk); t++; blen++; end
    endtask

    task automatic sw_conv(input int ch, output int blen);
        @(negedge clk);
        ch_mask  = 8'(1 << ch);
        start_sw = 1'b1;
        @(negedge clk);
        start_sw = 1'b0;
        wait_conv(blen);
    endtask

    task automatic rd(input int ch, output logic [9:0] d, output logic dn, output logic ov);
        @(negedge clk);
        rd_ch = 3'(ch);
        rd_en = 1'b1;
        #1;
        d  = rd_data;
        dn = rd_done;
        ov = rd_ovr;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic peek(input int ch, output logic [9:0] d, output logic dn, output logic ov);
        @(negedge clk);
        rd_ch = 3'(ch);
        #1;
        d  = rd_data;
        dn = rd_done;
        ov = rd_ovr;
    endtask

    task automatic clear_all();
        logic [9:0] d;
        logic dn, ov;
        for (int c = 0; c < 8; c++) rd(c, d, dn, ov);
    endtask

    task automatic idle_window(input int cyc, input string req);
        int r0 = n_rise;
        int seen = 0;
        for (int k = 0; k < cyc; k++) begin
            @(negedge clk);
            if (busy) seen++;
        end
        chk(seen == 0 && n_rise == r0, req, n_rise - r0, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [9:0] d;
        logic dn, ov;
        int blen;
        int r0;
        for (int c = 0; c < 8; c++) vin[c] = 10'd0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R7, R10, R2)
        chk(!busy && !sample && dac_code == 0, "R2 reset idle", int'(busy), 0);
        chk(!irq, "R10 reset irq", int'(irq), 0);
        for (int c = 0; c < 8; c++) begin
            peek(c, d, dn, ov);
            chk(!dn && !ov, "R7 reset flags", int'(dn), 0);
        end

        // R1: every input code on channel 0, fastest conversion clock
        clk_div = 8'd0;
        for (int v = 0; v < 1024; v++) begin
            vin[0] = 10'(v);
            sw_conv(0, blen);
            rd(0, d, dn, ov);
            chk(d == 10'(v) && dn, "R1 code sweep", int'(d), v);
        end

        // R2/R6/R7: dividers x channels, duration, isolation, read-clear
        foreach (vin[c]) vin[c] = 10'd0;
        for (int di = 0; di < 4; di++) begin
            int dv = (di == 3) ? 6 : di;
            clk_div = 8'(dv);
            for (int c = 0; c < 8; c++) begin
                vin[c] = 10'((c * 131 + dv * 37 + 5) % 1024);
                sw_conv(c, blen);
                chk(blen == 11 * (dv + 1), "R2 busy length", blen, 11 * (dv + 1));
            end
            for (int c = 0; c < 8; c++) begin
                rd(c, d, dn, ov);
                chk(d == vin[c] && dn && !ov, "R6 channel result", int'(d), int'(vin[c]));
                peek(c, d, dn, ov);
                chk(!dn, "R7 done cleared by read", int'(dn), 0);
                if (c < 7) begin
                    peek(c + 1, d, dn, ov);
                    chk(dn && d == vin[c + 1], "R6 neighbour undisturbed", int'(d), int'(vin[c + 1]));
                end
            end
        end

        // R8: overwrite without a read
        clk_div = 8'd1;
        vin[5] = 10'd300;
        sw_conv(5, blen);
        vin[5] = 10'd301;
        sw_conv(5, blen);
        rd(5, d, dn, ov);
        chk(ov && dn && d == 10'd301, "R8 overrun set", int'(ov), 1);
        rd(5, d, dn, ov);
        chk(!ov && !dn, "R8 overrun cleared", int'(ov), 0);

        // R3: lowest mask bit, one conversion, start ignored while busy
        clear_all();
        vin[3] = 10'd77;
        nlog = 0;
        r0 = n_rise;
        @(negedge clk);
        ch_mask  = 8'b0110_1000;
        start_sw = 1'b1;
        @(negedge clk);
        start_sw = 1'b0;
        while (!busy) @(negedge clk);
        repeat (6) @(negedge clk);
        start_sw = 1'b1;
        @(negedge clk);
        start_sw = 1'b0;
        wait_conv(blen);
        chk(log_ch[0] == 3, "R3 lowest channel", log_ch[0], 3);
        idle_window(60, "R3 start while busy ignored");
        chk(n_rise - r0 == 1, "R3 single conversion", n_rise - r0, 1);
        peek(3, d, dn, ov);
        chk(dn && d == 10'd77, "R3 result", int'(d), 77);
        peek(5, d, dn, ov);
        chk(!dn, "R3 higher channel untouched", int'(dn), 0);

        // R4: burst over channels 0,2,5,7 with wrap
        clear_all();
        for (int c = 0; c < 8; c++) vin[c] = 10'(100 + c);
        @(negedge clk);
        ch_mask = 8'b1010_0101;
        nlog = 0;
        burst_en = 1'b1;
        while (nlog < 6) @(negedge clk);
        burst_en = 1'b0;
        wait_conv(blen);
        begin
            int exp_seq [6] = '{0, 2, 5, 7, 0, 2};
            for (int k = 0; k < 6; k++)
                chk(log_ch[k] == exp_seq[k], "R4 scan order", log_ch[k], exp_seq[k]);
        end
        peek(1, d, dn, ov);
        chk(!dn, "R4 masked channel skipped", int'(dn), 0);
        rd(0, d, dn, ov);
        chk(ov && d == 10'd100, "R8 burst overrun", int'(ov), 1);
        rd(7, d, dn, ov);
        chk(dn && d == 10'd107, "R4 burst result", int'(d), 107);

        // R5: pin rising start, edges while busy ignored
        clear_all();
        ch_mask = 8'b0001_0000;
        vin[4] = 10'd512;
        trig_sel = 2'd1;
        trig_fall = 1'b0;
        r0 = n_rise;
        @(negedge clk);
        trig_pin = 1'b1;
        while (!busy) @(negedge clk);
        repeat (3) @(negedge clk);
        trig_pin = 1'b0;
        repeat (3) @(negedge clk);
        trig_pin = 1'b1;
        wait_conv(blen);
        idle_window(60, "R5 edge while busy ignored");
        chk(n_rise - r0 == 1, "R5 pin rising start", n_rise - r0, 1);
        rd(4, d, dn, ov);
        chk(dn && d == 10'd512, "R5 pin result", int'(d), 512);

        // R5: falling polarity
        trig_fall = 1'b1;
        @(negedge clk);
        trig_pin = 1'b0;
        wait_conv(blen);
        rd(4, d, dn, ov);
        chk(dn, "R5 falling edge start", int'(dn), 1);
        trig_pin = 1'b1;
        idle_window(60, "R5 wrong polarity ignored");

        // R5: timer-match pulse, pin ignored under timer selection
        trig_sel = 2'd2;
        trig_fall = 1'b0;
        @(negedge clk);
        trig_pin = 1'b0;
        idle_window(40, "R5 pin ignored under timer select");
        tmr_match = 1'b1;
        @(negedge clk);
        tmr_match = 1'b0;
        wait_conv(blen);
        rd(4, d, dn, ov);
        chk(dn, "R5 timer start", int'(dn), 1);
        trig_sel = 2'd0;
        @(negedge clk);
        trig_pin = 1'b1;
        tmr_match = 1'b1;
        @(negedge clk);
        tmr_match = 1'b0;
        idle_window(40, "R5 no source selected");

        // R9: power-down mid-conversion
        clear_all();
        vin[2] = 10'd222;
        sw_conv(2, blen);
        vin[1] = 10'd700;
        @(negedge clk);
        ch_mask = 8'b0000_0010;
        start_sw = 1'b1;
        @(negedge clk);
        start_sw = 1'b0;
        while (!busy) @(negedge clk);
        repeat (5) @(negedge clk);
        pwr_dn = 1'b1;
        @(negedge clk);
        chk(!busy && !sample && dac_code == 0 && ana_ch == 0, "R9 parked", int'(busy), 0);
        start_sw = 1'b1;
        @(negedge clk);
        start_sw = 1'b0;
        idle_window(30, "R9 start ignored in power-down");
        peek(1, d, dn, ov);
        chk(!dn, "R9 aborted conversion writes nothing", int'(dn), 0);
        peek(2, d, dn, ov);
        chk(dn && d == 10'd222, "R9 results kept", int'(d), 222);
        pwr_dn = 1'b0;
        sw_conv(1, blen);
        rd(1, d, dn, ov);
        chk(dn && d == 10'd700, "R9 resumes after power-up", int'(d), 700);

        // R10: interrupt follows enabled done flags
        clear_all();
        int_en = 8'b0000_1000;
        vin[4] = 10'd9;
        sw_conv(4, blen);
        @(negedge clk);
        chk(!irq, "R10 disabled channel", int'(irq), 0);
        vin[3] = 10'd10;
        sw_conv(3, blen);
        @(negedge clk);
        chk(irq, "R10 enabled channel", int'(irq), 1);
        rd(3, d, dn, ov);
        chk(!irq, "R10 cleared by read", int'(irq), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule